// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the five condition and power flags of a small 8-bit processor core: time-out, power-down, zero, digit carry and carry. The arithmetic flags follow each ALU operation. The ALU presents its 8-bit result, its carry or borrow out of bit 7, its carry or borrow out of bit 3 and an operation class, all qualified by a single valid strobe. The two power flags follow power-on, watchdog and sleep events. Software may write the arithmetic flags through a write port. The whole register can be read at any time on a combinational read port.

The ALU result stream carries only a valid strobe. The register takes a new result in every cycle, so the stream has no ready signal and never applies back-pressure. All event and write inputs are plain one-cycle strobes sampled on the rising clock edge. The power-on/brown-out reset is asynchronous. Every other reset type arrives as a synchronous strobe that freezes the register for that cycle.

The read port places carry at bit 0, digit carry at bit 1, zero at bit 2, power-down at bit 3 and time-out at bit 4. Bits 7 to 5 read as zero. Operation class encoding: 2'b00 add, 2'b01 subtract, 2'b10 logic, 2'b11 other.

Top module: `psr_status_reg`

## Requirements
- R1: The read port is {3'b000, TO, PD, Z, DC, C}, with C at bit 0 and TO at bit 4. Bits 7 to 5 always read 0.
- R2: While rst_por is high, and after it falls, TO and PD are 1 and Z, DC and C are 0, so the read value is 8'h18.
- R3: A cycle with other_rst high changes no flag. ALU updates, software writes and power events in that same cycle are all discarded.
- R4: A wdt_clear strobe sets both TO and PD to 1 on the next edge.
- R5: A sleep strobe sets TO to 1 and clears PD to 0. When sleep and wdt_clear occur together, PD is cleared.
- R6: A wdt_timeout strobe clears TO to 0 and leaves PD unchanged. Its effect on TO overrides sleep and wdt_clear in the same cycle.
- R7: For a valid add, subtract or logic operation, Z becomes 1 if alu_result is 8'h00 and 0 otherwise.
- R8: For a valid add (op 2'b00), C takes alu_cy (carry out of bit 7) and DC takes alu_hcy (carry out of bit 3).
- R9: For a valid subtract (op 2'b01), alu_cy and alu_hcy are borrows. C becomes the inverse of alu_cy and DC becomes the inverse of alu_hcy, so both are 1 when no borrow occurs.
- R10: A valid logic operation (op 2'b10) leaves C and DC unchanged. A valid "other" operation (op 2'b11) leaves Z, DC and C unchanged.
- R11: A software write (sw_we) loads sw_wdata[2:0] into C, DC and Z. sw_wdata[4:3] has no effect on TO and PD.
- R12: When a valid ALU operation and a software write occur in the same cycle, each flag that the operation updates takes the ALU value. The flags it leaves alone take the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_por | input | 1 | Asynchronous power-on/brown-out reset, active high |
| other_rst | input | 1 | Synchronous strobe for any other reset type; freezes all flags |
| wdt_clear | input | 1 | Watchdog-clear event strobe |
| sleep_enter | input | 1 | Sleep-entry event strobe |
| wdt_timeout | input | 1 | Watchdog time-out event strobe |
| alu_valid | input | 1 | ALU result valid; always accepted |
| alu_op | input | 2 | Operation class: 00 add, 01 subtract, 10 logic, 11 other |
| alu_result | input | 8 | ALU result |
| alu_cy | input | 1 | Carry (add) or borrow (subtract) out of bit 7 |
| alu_hcy | input | 1 | Carry (add) or borrow (subtract) out of bit 3 |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 8 | Software write data |
| rd_data | output | 8 | Full register read value |

## Verification
On every cycle, the assertions check the following: the freeze under other_rst, the time-out clearing of TO, the sleep clearing of PD, zero detection, carry inversion on subtract, and that C and DC hold through logic operations and TO and PD hold when no power event occurs. The assertions also check that the software write cannot reach TO and PD. The bench's scenarios are needed to show the post-reset value, the exact priority among events that arrive together, the merge of a software write with an ALU update, and the full read layout, including the zero upper bits. The bench's scenarios also run long random mixes, in which the flags must track an independent model across operation sequences.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int DATA_W  = 8;
  localparam int NFLAGS  = 5;
  localparam int BIT_C   = 0;
  localparam int BIT_DC  = 1;
  localparam int BIT_Z   = 2;
  localparam int BIT_PD  = 3;
  localparam int BIT_TO  = 4;
  localparam int SW_MSB  = BIT_Z;

  typedef enum logic [1:0] {
    OP_ADD   = 2'b00,
    OP_SUB   = 2'b01,
    OP_LOGIC = 2'b10,
    OP_OTHER = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic dc;
    logic c;
  } arith_flags_t;
endpackage

// File: rtl/psr_power_flags.sv
module psr_power_flags (
  input  logic clk,
  input  logic rst_por,
  input  logic hold,
  input  logic wdt_clear,
  input  logic sleep_enter,
  input  logic wdt_timeout,
  output logic to_q,
  output logic pd_q
);
  logic to_d, pd_d;

  always_comb begin
    to_d = to_q;
    pd_d = pd_q;
    if (wdt_clear) begin
      to_d = 1'b1;
      pd_d = 1'b1;
    end
    if (sleep_enter) begin
      to_d = 1'b1;
      pd_d = 1'b0;
    end
    if (wdt_timeout) to_d = 1'b0;
  end

  always_ff @(posedge clk or posedge rst_por) begin
    if (rst_por) begin
      to_q <= 1'b1;
      pd_q <= 1'b1;
    end else if (!hold) begin
      to_q <= to_d;
      pd_q <= pd_d;
    end
  end

  // R6: time-out always leaves TO cleared
  p_to_timeout_r6: assert property (@(posedge clk) disable iff (rst_por)
    (wdt_timeout && !hold) |=> !to_q);
  // R5: sleep leaves PD cleared
  p_pd_sleep_r5: assert property (@(posedge clk) disable iff (rst_por)
    (sleep_enter && !hold) |=> !pd_q);
  // R4: watchdog clear alone sets both
  p_clear_sets_r4: assert property (@(posedge clk) disable iff (rst_por)
    (wdt_clear && !sleep_enter && !wdt_timeout && !hold) |=> (to_q && pd_q));
  // R11: without a power event TO and PD never move
  p_power_hold_r11: assert property (@(posedge clk) disable iff (rst_por)
    (!wdt_clear && !sleep_enter && !wdt_timeout) |=> ($stable(to_q) && $stable(pd_q)));
endmodule

// File: rtl/psr_arith_flags.sv
module psr_arith_flags
  import psr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_por,
  input  logic              hold,
  input  logic              alu_valid,
  input  logic [1:0]        alu_op,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              alu_cy,
  input  logic              alu_hcy,
  input  logic              sw_we,
  input  logic [SW_MSB:0]   sw_wdata,
  output arith_flags_t      flags_q
);
  alu_op_e      op;
  logic         upd_z, upd_cy;
  logic         is_sub;
  arith_flags_t alu_val, sw_val, flags_d;

  assign op     = alu_op_e'(alu_op);
  assign is_sub = (op == OP_SUB);
  assign upd_z  = alu_valid && (op != OP_OTHER);
  assign upd_cy = alu_valid && ((op == OP_ADD) || is_sub);

  assign alu_val.z  = ~|alu_result;
  assign alu_val.c  = alu_cy  ^ is_sub;
  assign alu_val.dc = alu_hcy ^ is_sub;

  assign sw_val.c  = sw_wdata[BIT_C];
  assign sw_val.dc = sw_wdata[BIT_DC];
  assign sw_val.z  = sw_wdata[BIT_Z];

  always_comb begin
    flags_d = sw_we ? sw_val : flags_q;
    if (upd_z) flags_d.z = alu_val.z;
    if (upd_cy) begin
      flags_d.c  = alu_val.c;
      flags_d.dc = alu_val.dc;
    end
  end

  always_ff @(posedge clk or posedge rst_por) begin
    if (rst_por) flags_q <= '0;
    else if (!hold) flags_q <= flags_d;
  end

  // R7: zero flag mirrors the result after a flag-setting operation
  p_zero_detect_r7: assert property (@(posedge clk) disable iff (rst_por)
    (alu_valid && (alu_op != 2'b11) && !hold) |=> (flags_q.z == ($past(alu_result) == 8'h00)));
  // R9: subtract inverts the borrow inputs
  p_sub_invert_r9: assert property (@(posedge clk) disable iff (rst_por)
    (alu_valid && (alu_op == 2'b01) && !hold) |=> (flags_q.c == !$past(alu_cy) && flags_q.dc == !$past(alu_hcy)));
  // R10: logic operations keep carry flags when software is quiet
  p_logic_keep_r10: assert property (@(posedge clk) disable iff (rst_por)
    (alu_valid && (alu_op == 2'b10) && !sw_we) |=> ($stable(flags_q.c) && $stable(flags_q.dc)));
endmodule

// File: rtl/psr_status_reg.sv
module psr_status_reg
  import psr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_por,
  input  logic        other_rst,
  input  logic        wdt_clear,
  input  logic        sleep_enter,
  input  logic        wdt_timeout,
  input  logic        alu_valid,
  input  logic [1:0]  alu_op,
  input  logic [7:0]  alu_result,
  input  logic        alu_cy,
  input  logic        alu_hcy,
  input  logic        sw_we,
  input  logic [7:0]  sw_wdata,
  output logic [7:0]  rd_data
);
  logic         to_q, pd_q;
  arith_flags_t af;

  psr_power_flags u_power (
    .clk         (clk),
    .rst_por     (rst_por),
    .hold        (other_rst),
    .wdt_clear   (wdt_clear),
    .sleep_enter (sleep_enter),
    .wdt_timeout (wdt_timeout),
    .to_q        (to_q),
    .pd_q        (pd_q)
  );

  psr_arith_flags u_arith (
    .clk        (clk),
    .rst_por    (rst_por),
    .hold       (other_rst),
    .alu_valid  (alu_valid),
    .alu_op     (alu_op),
    .alu_result (alu_result),
    .alu_cy     (alu_cy),
    .alu_hcy    (alu_hcy),
    .sw_we      (sw_we),
    .sw_wdata   (sw_wdata[SW_MSB:0]),
    .flags_q    (af)
  );

  always_comb begin
    rd_data         = '0;
    rd_data[BIT_C]  = af.c;
    rd_data[BIT_DC] = af.dc;
    rd_data[BIT_Z]  = af.z;
    rd_data[BIT_PD] = pd_q;
    rd_data[BIT_TO] = to_q;
  end

  // R3: another reset type freezes the whole register
  p_other_hold_r3: assert property (@(posedge clk) disable iff (rst_por)
    other_rst |=> $stable(rd_data));
  // R1: upper bits never read as one
  p_upper_zero_r1: assert property (@(posedge clk) disable iff (rst_por)
    rd_data[7:5] == 3'b000);
endmodule

// File: tb/psr_status_reg_tb.sv
module psr_status_reg_tb;
  logic clk = 0;
  always #10 clk = ~clk;

  logic       rst_por, other_rst, wdt_clear, sleep_enter, wdt_timeout;
  logic       alu_valid, alu_cy, alu_hcy, sw_we;
  logic [1:0] alu_op;
  logic [7:0] alu_result, sw_wdata, rd_data;

  psr_status_reg u_dut (
    .clk(clk), .rst_por(rst_por), .other_rst(other_rst),
    .wdt_clear(wdt_clear), .sleep_enter(sleep_enter), .wdt_timeout(wdt_timeout),
    .alu_valid(alu_valid), .alu_op(alu_op), .alu_result(alu_result),
    .alu_cy(alu_cy), .alu_hcy(alu_hcy), .sw_we(sw_we), .sw_wdata(sw_wdata),
    .rd_data(rd_data)
  );

  int compared = 0, mismatched = 0;
  logic m_to, m_pd, m_z, m_dc, m_c;
  bit done = 0;

  function automatic logic [7:0] model_read();
    return {3'b000, m_to, m_pd, m_z, m_dc, m_c};
  endfunction

  task automatic check(input string tag, input logic [7:0] exp);
    compared++;
    if (rd_data !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %02h expected %02h", tag, rd_data, exp);
    end
  endtask

  task automatic idle();
    other_rst = 0; wdt_clear = 0; sleep_enter = 0; wdt_timeout = 0;
    alu_valid = 0; alu_op = 2'b11; alu_result = 8'h00; alu_cy = 0; alu_hcy = 0;
    sw_we = 0; sw_wdata = 8'h00;
  endtask

  // set ALU inputs from operands, computing carries/borrows independently
  task automatic set_alu(input logic [1:0] op, input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    alu_valid = 1; alu_op = op;
    case (op)
      2'b00: begin
        s = {1'b0, a} + {1'b0, b};
        alu_result = s[7:0]; alu_cy = s[8];
        alu_hcy = ({1'b0, a[3:0]} + {1'b0, b[3:0]}) > 5'd15;
      end
      2'b01: begin
        alu_result = a - b; alu_cy = (a < b); alu_hcy = (a[3:0] < b[3:0]);
      end
      2'b10: begin alu_result = a & b; alu_cy = a[0]; alu_hcy = b[0]; end
      default: begin alu_result = a ^ b; alu_cy = a[1]; alu_hcy = b[1]; end
    endcase
  endtask

  // reference update from current inputs
  task automatic model_step();
    logic nz, ndc, nc, nto, npd;
    if (other_rst) return;
    nto = m_to; npd = m_pd;
    if (wdt_clear) begin nto = 1; npd = 1; end
    if (sleep_enter) begin nto = 1; npd = 0; end
    if (wdt_timeout) nto = 0;
    nz = m_z; ndc = m_dc; nc = m_c;
    if (sw_we) begin nc = sw_wdata[0]; ndc = sw_wdata[1]; nz = sw_wdata[2]; end
    if (alu_valid && alu_op != 2'b11) nz = (alu_result == 8'h00);
    if (alu_valid && alu_op == 2'b00) begin nc = alu_cy; ndc = alu_hcy; end
    if (alu_valid && alu_op == 2'b01) begin nc = !alu_cy; ndc = !alu_hcy; end
    m_to = nto; m_pd = npd; m_z = nz; m_dc = ndc; m_c = nc;
  endtask

  task automatic cycle(input string tag);
    model_step();
    @(posedge clk); #2;
    idle();
    check(tag, model_read());
  endtask

  task automatic por();
    @(negedge clk); rst_por = 1; #3;
    m_to = 1; m_pd = 1; m_z = 0; m_dc = 0; m_c = 0;
    check("R2 during reset", 8'h18);
    @(negedge clk); rst_por = 0;
    @(negedge clk);
    check("R2 after reset", 8'h18);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd1234);
    idle(); rst_por = 0;
    por();

    @(negedge clk);
    // R8 add with both carries: 0xF8+0x18 = 0x110
    set_alu(2'b00, 8'hF8, 8'h18); cycle("R8 add carry");
    if (rd_data[2:0] !== 3'b011) begin mismatched++; $display("FAIL R8: actual %0b expected 011", rd_data[2:0]); end
    compared++;
    // R7 zero on add wrap 0x80+0x80
    set_alu(2'b00, 8'h80, 8'h80); cycle("R7 add zero");
    if (rd_data[2] !== 1'b1) begin mismatched++; $display("FAIL R7: actual %0b expected 1", rd_data[2]); end
    compared++;
    // R9 sub greater minus smaller: no borrow -> C=DC=1
    set_alu(2'b01, 8'h35, 8'h12); cycle("R9 sub no borrow");
    if (rd_data[1:0] !== 2'b11) begin mismatched++; $display("FAIL R9: actual %0b expected 11", rd_data[1:0]); end
    compared++;
    set_alu(2'b01, 8'h12, 8'h35); cycle("R9 sub borrow");
    set_alu(2'b01, 8'h44, 8'h44); cycle("R9 sub equal");
    // R10 logic keeps C/DC, other keeps all
    set_alu(2'b00, 8'hFF, 8'h01); cycle("R8 setup");
    set_alu(2'b10, 8'hF0, 8'h0F); cycle("R10 logic keeps carries");
    set_alu(2'b11, 8'h5A, 8'h00); cycle("R10 other keeps all");
    // R11 software write, TO/PD bits ignored
    sw_we = 1; sw_wdata = 8'hE2; cycle("R11 sw write");
    wdt_timeout = 1; cycle("R6 timeout");
    sw_we = 1; sw_wdata = 8'h1F; cycle("R11 sw cannot set TO");
    // R12 merge: logic op + write: Z from ALU, C/DC from write
    sw_we = 1; sw_wdata = 8'h07; set_alu(2'b10, 8'h0F, 8'hF0); cycle("R12 logic merge");
    sw_we = 1; sw_wdata = 8'h00; set_alu(2'b00, 8'hFF, 8'hFF); cycle("R12 add beats write");
    // R4 / R5 / R6 events and priorities
    wdt_clear = 1; cycle("R4 clear");
    sleep_enter = 1; cycle("R5 sleep");
    wdt_clear = 1; sleep_enter = 1; cycle("R5 sleep beats clear");
    wdt_clear = 1; wdt_timeout = 1; cycle("R6 timeout beats clear");
    sleep_enter = 1; wdt_timeout = 1; cycle("R6 timeout beats sleep");
    // R3 other reset freezes everything
    other_rst = 1; wdt_clear = 1; sw_we = 1; sw_wdata = 8'h07; cycle("R3 freeze");
    other_rst = 1; set_alu(2'b00, 8'h00, 8'h00); cycle("R3 freeze alu");
    // R2 reset from a busy state
    wdt_timeout = 1; sleep_enter = 1; sw_we = 1; sw_wdata = 8'h07; cycle("R6 setup");
    por();

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if ($urandom_range(0, 1)) set_alu(2'($urandom_range(0, 3)), 8'($urandom), 8'($urandom));
      if ($urandom_range(0, 9) < 2) begin sw_we = 1; sw_wdata = 8'($urandom); end
      wdt_clear   = ($urandom_range(0, 9) == 0);
      sleep_enter = ($urandom_range(0, 9) == 0);
      wdt_timeout = ($urandom_range(0, 9) == 0);
      other_rst   = (r < 5);
      if (other_rst) cycle("R3 random");
      else if (alu_valid && alu_op == 2'b01) cycle("R9 random");
      else if (alu_valid && alu_op == 2'b00) cycle("R8 random");
      else if (alu_valid) cycle("R10 random");
      else if (sw_we) cycle("R11 random");
      else if (wdt_timeout) cycle("R6 random");
      else if (sleep_enter) cycle("R5 random");
      else cycle("R1 random");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule